// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt events for a small 8-bit processor and reports them in priority order. It handles eight external lines, thirteen single-cycle pulses from on-chip peripherals and a software break request. These events feed seventeen vector slots. Slot 1 is the reset vector and slot 17 is the break instruction. Slots 2 to 16 are maskable. Each maskable slot has a latched request bit and an enable bit. A single global disable flag gates all maskable slots together.

The processor raises `ack` while `irq` is high. In that same cycle the block shows the winning slot number and the low byte address of its two-byte vector. At the next clock edge it clears that slot's request and sets the global disable flag. Several slots are shared between sources. A select register picks which source drives each shared slot. Serial sources that are not selected can never set a request.

Software reaches the block through a small write port and a combinational read port. Request bits accept writes of 0 only. Enables, edge polarities, source selects and the disable flag can be both read and written.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, all request, enable, polarity and select registers read 0 and the disable flag (address 6, bit 0) reads 1. A reset vector is pending, so `irq` is high, and the first acknowledge reports slot 1 at address 0xFFFC whatever the flag holds.
- R2: A maskable slot drives `irq` only when its request bit is 1, its enable bit is 1 and the disable flag is 0. Request and enable bits for slots 2 to 9 sit in bits 0 to 7 of addresses 0 (request) and 2 (enable). Slots 10 to 16 sit in bits 0 to 6 of addresses 1 and 3.
- R3: Of all accepted slots, the one with the lowest number wins. Reset (slot 1) is highest and break (slot 17) is lowest.
- R4: While `ack` is high, `ack_slot` holds the 5-bit winning slot number n and `ack_vec` holds 0xFFFC − 2·(n−1), in the same cycle.
- R5: At the clock edge where `ack` and `irq` are both high, the winning request bit is cleared and the disable flag is set to 1.
- R6: External line i passes through two synchronizer flops and then sets its slot's request on a rising edge when polarity bit i (address 4) is 1, or on a falling edge when it is 0. The request bit is readable 3 clocks after the pin changes. The opposite edge does nothing. Changing a polarity bit while the pin is steady sets no request. Lines 0, 1, 2, 3, 4, 5, 6 and 7 feed slots 2, 3, 13, 14, 15, 10, 11 and 16.
- R7: When software writes to address 0 or 1, each request bit written as 0 is cleared and each bit written as 1 is left unchanged. A new event in the same cycle wins over the clear.
- R8: Select register (address 5) controls the shared slots:
  - bit 0 = 1 routes timer Z to slot 3; 0 routes line 1 there.
  - bit 1 = 1 routes serial 2 to slot 12; 0 routes serial 3 receive there.
  - bit 2 = 1 routes timer Z to slot 13; 0 routes line 2 there.
  - bits 4:3 pick slot 16's source: 0 = line 7, 1 = A/D done, 2 = serial 3 transmit, 3 = none.
  - A source that is not routed sets no request.
- R9: Serial 1 receive (slot 4) and transmit (slot 5) count only when select bit 7 is 1. Select bit 5 picks which serial 1 transmit pulse feeds slot 5, and bit 6 does the same for serial 3: 1 = buffer empty, 0 = shift complete.
- R10: While `brk_req` is high, `irq` is high regardless of the disable flag or any enable bit. The break slot has no request or enable bit.
- R11: `src_pulse` bits map as follows: 0 timer Z, 1 serial 1 rx, 2 serial 1 tx done, 3 serial 1 tx empty, 4 timer X (slot 6), 5 timer Y (slot 7), 6 timer 1 (slot 8), 7 timer 2 (slot 9), 8 serial 3 rx, 9 serial 2, 10 serial 3 tx done, 11 serial 3 tx empty, 12 A/D done. A high bit sets the routed slot's request at that clock edge.
- R12: `irq` is combinational from the stored state. It is low in the cycle right after the edge that clears or masks the last accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 8 | Asynchronous external interrupt lines |
| src_pulse | input | 13 | Single-cycle peripheral event pulses |
| brk_req | input | 1 | Break instruction in execution (level) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ack | input | 1 | Processor acknowledge |
| irq | output | 1 | Interrupt request to the processor |
| ack_slot | output | 5 | Winning slot number, 0 when none |
| ack_vec | output | 16 | Low byte address of the winning vector |

## Verification
The bench targets several corner cases. Two requests can be pending together: a wrong arbiter would serve the later slot first, or would keep `irq` high after the acknowledge set the disable flag. A polarity change is made while a line is steady: a detector that compares against the new polarity instead of the previous sample would raise a false request. The opposite edge is also driven and must be ignored. Writing all ones to a request register must not set anything. Unrouted timer and serial pulses, and serial 1 pulses sent while serial 1 is inactive, must leave the request registers at zero. Break must still be served with the flag set. A pending higher slot must beat it when the flag is clear.

// File: rtl/pvic_pkg.sv
// Shared constants and helpers for the fixed-priority vectored interrupt controller.
// Assumes slot numbering 1..17 with slot 1 highest priority.
package pvic_pkg;
    localparam int SLOTS    = 17;
    localparam int SLOT_W   = 5;
    localparam int MASKABLE = 15;
    localparam int N_EXT    = 8;
    localparam int N_PULSE  = 13;
    localparam int SYNC_STAGES = 2;
    localparam logic [15:0] VEC_TOP = 16'hFFFC;

    localparam logic [2:0] A_REQ_LO = 3'd0;
    localparam logic [2:0] A_REQ_HI = 3'd1;
    localparam logic [2:0] A_EN_LO  = 3'd2;
    localparam logic [2:0] A_EN_HI  = 3'd3;
    localparam logic [2:0] A_POL    = 3'd4;
    localparam logic [2:0] A_SEL    = 3'd5;
    localparam logic [2:0] A_FLAG   = 3'd6;

    localparam int P_TZ = 0, P_S1RX = 1, P_S1DONE = 2, P_S1EMPTY = 3;
    localparam int P_TX = 4, P_TY = 5, P_T1 = 6, P_T2 = 7;
    localparam int P_S3RX = 8, P_S2 = 9, P_S3DONE = 10, P_S3EMPTY = 11, P_ADC = 12;

    // Low byte address of the vector for a given slot number.
    function automatic logic [15:0] slot_vec(input logic [SLOT_W-1:0] s);
        return VEC_TOP + 16'd2 - {10'd0, s, 1'b0};
    endfunction
endpackage

// File: rtl/pvic_edge.sv
// Synchronizes each external line and flags a single-cycle edge of the selected polarity.
// Assumes SYNC_STAGES >= 2 and that lines are low while reset is applied.
module pvic_edge #(
    parameter int N_EXT = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] pol_rise,
    output logic [N_EXT-1:0] edge_hit
);
    for (genvar i = 0; i < N_EXT; i++) begin : g_line
        logic [SYNC_STAGES-1:0] sh;
        logic prev;
        logic s;
        assign s = sh[SYNC_STAGES-1];

        // Shift the raw pin through the synchronizer and keep the last synced value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[SYNC_STAGES-2:0], pin[i]};
                prev <= s;
            end
        end

        // Compare the synced value with the previous sample, not with the polarity setting.
        assign edge_hit[i] = pol_rise[i] ? (s & ~prev) : (~s & prev);

        // R6: a steady synced line never reports an edge, whatever the polarity does
        p_no_spurious_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(s) && $stable(prev) |-> !edge_hit[i]);
    end
endmodule

// File: rtl/pvic_route.sv
// Routes edges and peripheral pulses onto the fifteen maskable slots under the select register.
// Purely combinational; bit k of set_req belongs to slot k+2.
module pvic_route
    import pvic_pkg::*;
(
    input  logic [N_EXT-1:0]    edge_hit,
    input  logic [N_PULSE-1:0]  pulse,
    input  logic [7:0]          sel,
    output logic [MASKABLE-1:0] set_req
);
    logic s1_on;
    logic s1_tx;
    logic s3_tx;
    assign s1_on = sel[7];
    assign s1_tx = sel[5] ? pulse[P_S1EMPTY] : pulse[P_S1DONE];
    assign s3_tx = sel[6] ? pulse[P_S3EMPTY] : pulse[P_S3DONE];

    // Build the per-slot set strobes from the routed sources.
    always_comb begin
        set_req[0]  = edge_hit[0];
        set_req[1]  = sel[0] ? pulse[P_TZ] : edge_hit[1];
        set_req[2]  = s1_on & pulse[P_S1RX];
        set_req[3]  = s1_on & s1_tx;
        set_req[4]  = pulse[P_TX];
        set_req[5]  = pulse[P_TY];
        set_req[6]  = pulse[P_T1];
        set_req[7]  = pulse[P_T2];
        set_req[8]  = edge_hit[5];
        set_req[9]  = edge_hit[6];
        set_req[10] = sel[1] ? pulse[P_S2] : pulse[P_S3RX];
        set_req[11] = sel[2] ? pulse[P_TZ] : edge_hit[2];
        set_req[12] = edge_hit[3];
        set_req[13] = edge_hit[4];
        case (sel[4:3])
            2'd0:    set_req[14] = edge_hit[7];
            2'd1:    set_req[14] = pulse[P_ADC];
            2'd2:    set_req[14] = s3_tx;
            default: set_req[14] = 1'b0;
        endcase
    end
endmodule

// File: rtl/pvic_arb.sv
// Fixed-priority pick among reset, accepted maskable slots and break; outputs slot and vector.
// Assumes cand already includes request, enable and disable-flag qualification.
module pvic_arb
    import pvic_pkg::*;
(
    input  logic                rst_pend,
    input  logic [MASKABLE-1:0] cand,
    input  logic                brk,
    output logic                irq,
    output logic [SLOT_W-1:0]   win_slot,
    output logic [15:0]         win_vec,
    output logic [MASKABLE-1:0] grant
);
    // Lowest slot number wins: later assignments override earlier ones.
    always_comb begin
        win_slot = '0;
        if (brk) win_slot = SLOT_W'(SLOTS);
        for (int k = MASKABLE - 1; k >= 0; k--) begin
            if (cand[k]) win_slot = SLOT_W'(k + 2);
        end
        if (rst_pend) win_slot = SLOT_W'(1);
    end

    // One-hot grant for the maskable slot that won.
    always_comb begin
        for (int k = 0; k < MASKABLE; k++) grant[k] = (win_slot == SLOT_W'(k + 2));
    end

    assign irq     = rst_pend | brk | (|cand);
    assign win_vec = irq ? slot_vec(win_slot) : 16'd0;
endmodule

// File: rtl/prio_vec_intc.sv
// Top of the vectored interrupt controller: holds request, enable, polarity, select
// and disable state, and serves acknowledges. Assumes ack is only meaningful while irq is high.
module prio_vec_intc
    import pvic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EXT-1:0]   ext_pin,
    input  logic [N_PULSE-1:0] src_pulse,
    input  logic               brk_req,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [2:0]         rd_addr,
    output logic [7:0]         rd_data,
    input  logic               ack,
    output logic               irq,
    output logic [SLOT_W-1:0]  ack_slot,
    output logic [15:0]        ack_vec
);
    logic [MASKABLE-1:0] req, en, set_req, cand, grant, req_nx;
    logic [N_EXT-1:0]    pol, edge_hit;
    logic [7:0]          sel;
    logic                dis, rst_pend, take;

    pvic_edge #(.N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pol_rise(pol), .edge_hit(edge_hit));

    pvic_route u_route (.edge_hit(edge_hit), .pulse(src_pulse), .sel(sel), .set_req(set_req));

    assign cand = req & en & {MASKABLE{~dis}};

    pvic_arb u_arb (.rst_pend(rst_pend), .cand(cand), .brk(brk_req), .irq(irq),
                    .win_slot(ack_slot), .win_vec(ack_vec), .grant(grant));

    assign take = ack & irq;

    // Next request state: software clears, acknowledge clears, new events win last.
    always_comb begin
        req_nx = req;
        if (wr_en && wr_addr == A_REQ_LO) req_nx[7:0]  = req[7:0] & wr_data;
        if (wr_en && wr_addr == A_REQ_HI) req_nx[14:8] = req[14:8] & wr_data[6:0];
        if (take) req_nx = req_nx & ~grant;
        req_nx = req_nx | set_req;
    end

    // Register update for requests, configuration, disable flag and reset vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= '0;
            en       <= '0;
            pol      <= '0;
            sel      <= '0;
            dis      <= 1'b1;
            rst_pend <= 1'b1;
        end else begin
            req <= req_nx;
            if (wr_en && wr_addr == A_EN_LO) en[7:0]  <= wr_data;
            if (wr_en && wr_addr == A_EN_HI) en[14:8] <= wr_data[6:0];
            if (wr_en && wr_addr == A_POL)   pol      <= wr_data;
            if (wr_en && wr_addr == A_SEL)   sel      <= wr_data;
            if (take) dis <= 1'b1;
            else if (wr_en && wr_addr == A_FLAG) dis <= wr_data[0];
            if (take && ack_slot == SLOT_W'(1)) rst_pend <= 1'b0;
        end
    end

    // Combinational register read-back.
    always_comb begin
        case (rd_addr)
            A_REQ_LO: rd_data = req[7:0];
            A_REQ_HI: rd_data = {1'b0, req[14:8]};
            A_EN_LO:  rd_data = en[7:0];
            A_EN_HI:  rd_data = {1'b0, en[14:8]};
            A_POL:    rd_data = pol;
            A_SEL:    rd_data = sel;
            A_FLAG:   rd_data = {7'd0, dis};
            default:  rd_data = 8'd0;
        endcase
    end

    // R5: an accepted acknowledge leaves the disable flag set
    p_ack_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> dis);
    // R5: the granted request is gone after the acknowledge unless re-raised
    p_ack_clears_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && ((grant & set_req) == '0) |=> ((req & $past(grant)) == '0));
    // R2: with the flag set only reset or break can request service
    p_flag_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dis && !rst_pend && !brk_req |-> !irq);
    // R7: writing ones cannot create request bits
    p_write_one_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_REQ_LO && req[7:0] == 8'd0 && set_req[7:0] == 8'd0
        |=> req[7:0] == 8'd0);
    // R10: break always raises irq
    p_break_nonmaskable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> irq);
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_pin = '0;
    logic [12:0] src_pulse = '0;
    logic        brk_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        ack = 1'b0;
    logic        irq;
    logic [4:0]  ack_slot;
    logic [15:0] ack_vec;

    int total = 0;
    int bad = 0;
    logic [20:0] exp_q[$];

    always #2 clk = ~clk;

    prio_vec_intc u_dut (.clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_pulse(src_pulse),
        .brk_req(brk_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack), .irq(irq),
        .ack_slot(ack_slot), .ack_vec(ack_vec));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
        @(negedge clk); rd_addr = a; #1;
        check(tag, int'(rd_data), exp);
    endtask

    task automatic irq_chk(input string tag, input int exp);
        @(negedge clk); #1;
        check(tag, int'(irq), exp);
    endtask

    task automatic pulse(input int b);
        @(negedge clk); src_pulse[b] = 1'b1;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk); ext_pin[i] = v;
        repeat (4) @(negedge clk);
    endtask

    // Driver: push the expected slot and vector, then raise ack for one cycle.
    task automatic ack_exp(input int slot);
        logic [15:0] v;
        v = 16'hFFFC - 16'(2 * (slot - 1));
        @(negedge clk);
        exp_q.push_back({5'(slot), v});
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    // Monitor: compare acknowledge outputs with the scoreboard.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (ack) begin
                logic [20:0] e;
                if (exp_q.size() == 0) begin
                    check("R4 unexpected ack", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check("R4 slot", int'(ack_slot), int'(e[20:16]));
                    check("R4 vector", int'(ack_vec), int'(e[15:0]));
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 req lo", 3'd0, 0);
        rd_chk("R1 en lo", 3'd2, 0);
        rd_chk("R1 sel", 3'd5, 0);
        rd_chk("R1 flag", 3'd6, 1);
        irq_chk("R1 reset pending irq", 1);
        ack_exp(1);
        irq_chk("R12 irq low after reset served", 0);

        wr(3'd2, 8'hFF); wr(3'd3, 8'h7F); wr(3'd4, 8'hFF);
        wr(3'd5, 8'h80); wr(3'd6, 8'h00);
        irq_chk("R2 nothing pending", 0);

        // R3 priority with two pending (R11 timer X and timer 2)
        pulse(7); pulse(4);
        ack_exp(6);
        irq_chk("R5 flag masks remaining request", 0);
        rd_chk("R5 flag set", 3'd6, 1);
        rd_chk("R5 slot 6 cleared, slot 9 left", 3'd0, 8'h80);
        wr(3'd6, 8'h00);
        irq_chk("R2 accepted after flag clear", 1);
        ack_exp(9);

        // R2 masked slot and R7 software clear / write-one
        wr(3'd6, 8'h00); wr(3'd2, 8'hDF);
        pulse(5);
        irq_chk("R2 disabled slot no irq", 0);
        rd_chk("R2 request latched while disabled", 3'd0, 8'h20);
        wr(3'd0, 8'hDF);
        rd_chk("R7 zero write clears", 3'd0, 0);
        wr(3'd0, 8'hFF);
        rd_chk("R7 one write inert", 3'd0, 0);
        wr(3'd2, 8'hFF);

        // R6 external edges
        set_pin(0, 1'b1);
        rd_chk("R6 rising edge line 0", 3'd0, 8'h01);
        ack_exp(2);
        wr(3'd6, 8'h00);
        set_pin(0, 1'b0);
        rd_chk("R6 opposite edge ignored", 3'd0, 0);
        wr(3'd4, 8'hF7);
        rd_chk("R6 polarity change no request", 3'd1, 0);
        set_pin(3, 1'b1);
        rd_chk("R6 rising ignored on falling line", 3'd1, 0);
        set_pin(3, 1'b0);
        rd_chk("R6 falling edge line 3 slot 14", 3'd1, 8'h10);
        ack_exp(14);
        wr(3'd6, 8'h00);

        // R8 shared slots
        pulse(0);
        rd_chk("R8 unrouted timer Z lo", 3'd0, 0);
        rd_chk("R8 unrouted timer Z hi", 3'd1, 0);
        wr(3'd5, 8'h81);
        pulse(0);
        ack_exp(3);
        wr(3'd6, 8'h00);

        // R9 serial 1 gating and transmit mode
        wr(3'd5, 8'h00);
        pulse(1);
        rd_chk("R9 serial 1 inactive", 3'd0, 0);
        wr(3'd5, 8'h80);
        pulse(1);
        ack_exp(4);
        wr(3'd6, 8'h00);
        pulse(3);
        rd_chk("R9 empty pulse ignored in shift mode", 3'd0, 0);
        pulse(2);
        ack_exp(5);
        wr(3'd6, 8'h00);

        // R8 slot 16 source select
        wr(3'd5, 8'h88);
        pulse(12);
        ack_exp(16);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'h90);
        pulse(12);
        rd_chk("R8 A/D ignored when serial 3 tx routed", 3'd1, 0);

        // R10 break non-maskable, R3 lowest priority
        wr(3'd6, 8'h01);
        @(negedge clk); brk_req = 1'b1;
        irq_chk("R10 break with flag set", 1);
        ack_exp(17);
        wr(3'd6, 8'h00);
        pulse(6);
        ack_exp(8);
        @(negedge clk); brk_req = 1'b0;
        wr(3'd6, 8'h00);
        irq_chk("R12 irq low when idle", 0);

        repeat (2) @(negedge clk);
        check("R4 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule